// File: doc/BRIEF.md
# Frame Capture Address Generator

This block loads one frame of digitized video into a byte-wide frame-buffer RAM. When the host processor raises its start request, the block takes the RAM address, data and write-enable lines away from the processor. It waits for the next field sync, then steps a pixel address through the frame in raster order. Each address advances only on a pixel strobe during active video. Every strobed A/D sample is written at the current address.

The line counter moves on each line sync and returns to zero on field sync. The pixel counter returns to zero on each line sync. Pixel strobes beyond the end of a line, or beyond the last line, write nothing. Once the final pixel of the frame has been written, the block releases the RAM bus back to the processor and raises a done flag. The flag holds until the processor withdraws its request. The frame geometry is chosen by a two-bit mode input, which is sampled only at the moment a request is accepted. Four geometries are available: 256 or 512 pixels wide, each at full or half height.

Top module: `frame_capture_agen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `done` and `bus_own` are 0, and the RAM port mirrors the processor inputs, including `cpu_we`.
- R2: A capture is accepted only when `start_req` is high while the block is idle. From the next cycle, `bus_own` is 1 and the processor's write enable no longer reaches `ram_we`.
- R3: After acceptance, nothing is written until a field sync is seen. The first write of the frame goes to address 0.
- R4: Each pixel strobe in active video writes the `adc_data` byte of that cycle. The write appears on `ram_we`/`ram_addr`/`ram_wdata` one cycle later, at address (line << log2(width)) | pixel. Successive strobes in a line use successive pixel numbers.
- R5: A line sync clears the pixel number and advances the line. A strobe in the same cycle as a line sync writes nothing, and strobes after the last pixel of a line write nothing.
- R6: `mode_sel` bit 0 selects the width (0: 2^BASE_LOG, 1: 2^(BASE_LOG+1)). Bit 1 selects half height. With the default BASE_LOG=8 this gives 00=256×256, 01=512×512, 10=256×128 and 11=512×256, and exactly width×height bytes are written per frame.
- R7: The write of the last pixel of the frame is still driven with `bus_own`=1. On the next cycle, `done` is 1 and `bus_own` is 0.
- R8: `done` stays 1 as long as `start_req` stays high. It clears in the cycle after `start_req` is seen low.
- R9: During a capture, changes on `mode_sel` and `start_req` have no effect on the geometry or on bus ownership.
- R10: While the bus is released, `ram_addr`, `ram_wdata` and `ram_we` equal `cpu_addr`, `cpu_wdata` and `cpu_we`.
- R11: A field sync in the middle of a capture restarts the frame at line 0, pixel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Processor capture request |
| mode_sel | input | 2 | Geometry select: bit 0 wide, bit 1 half height |
| done | output | 1 | Frame complete, held until the request drops |
| field_sync | input | 1 | One-cycle field start strobe |
| line_sync | input | 1 | One-cycle line start strobe |
| pix_valid | input | 1 | Pixel strobe during active video |
| adc_data | input | DATA_W | Digitized sample |
| cpu_addr | input | 2*(BASE_LOG+1) | Processor RAM address |
| cpu_wdata | input | DATA_W | Processor RAM write data |
| cpu_we | input | 1 | Processor RAM write enable |
| ram_addr | output | 2*(BASE_LOG+1) | Frame-buffer address |
| ram_wdata | output | DATA_W | Frame-buffer write data |
| ram_we | output | 1 | Frame-buffer write enable |
| bus_own | output | 1 | 1 while the block owns the RAM bus |

## Verification
The assertions check several rules on every cycle. A capture write never occurs without bus ownership. Done rises only directly after the final write. Done holds while the request stays high. The latched mode never moves while the bus is owned. Within a line, each write advances the pixel number by one, and a line sync clears it. The bench scenarios are needed for the rest. They show the raster order of addresses and the sample values in each geometry, and that nothing is written before the field sync or past the line end. They also show the restart on a mid-frame field sync, and that mode changes made during a capture have no effect.

// File: rtl/fcap_pkg.sv
// Shared definitions for the frame capture address generator.
// Assumes mode bit 0 selects the wide line and mode bit 1 selects half height.
package fcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // processor owns the RAM
        ST_ARM  = 3'd1,   // request accepted, waiting for field start
        ST_CAPT = 3'd2,   // writing pixels
        ST_LAST = 3'd3,   // final write on the bus
        ST_DONE = 3'd4    // bus released, done flag up
    } cap_state_t;

    localparam int MODE_WIDE_BIT = 0;
    localparam int MODE_HALF_BIT = 1;

endpackage

// File: rtl/fcap_geom.sv
// Geometry decoder: turns the latched two-bit mode into the last pixel
// index of a line and the last line index of a frame.
// Assumes BASE_LOG >= 2, so that a half-height narrow frame has at least two lines.
module fcap_geom #(
    parameter int BASE_LOG = 8,
    localparam int SPAN_W  = BASE_LOG + 1
) (
    input  logic [1:0]        mode,
    output logic              wide,
    output logic [SPAN_W-1:0] w_last,
    output logic [SPAN_W-1:0] h_last
);
    import fcap_pkg::*;

    logic half;

    // Decode width and height limits from the mode bits.
    always_comb begin
        wide   = mode[MODE_WIDE_BIT];
        half   = mode[MODE_HALF_BIT];
        w_last = wide ? {SPAN_W{1'b1}} : {1'b0, {BASE_LOG{1'b1}}};
        case ({wide, half})
            2'b10:   h_last = {SPAN_W{1'b1}};
            2'b01:   h_last = {2'b00, {(BASE_LOG-1){1'b1}}};
            default: h_last = {1'b0, {BASE_LOG{1'b1}}};
        endcase
    end

endmodule

// File: rtl/fcap_seq.sv
// Capture sequencer: accepts the processor request, latches the mode,
// waits for field start, runs the capture and holds the done flag.
// Assumes field_sync and last_fire are single-cycle strobes.
module fcap_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic [1:0] mode_in,
    input  logic       field_sync,
    input  logic       last_fire,
    output logic [1:0] mode_q,
    output logic       run,
    output logic       restart,
    output logic       bus_own,
    output logic       done
);
    import fcap_pkg::*;

    cap_state_t st_q, st_d;

    // Next-state decision.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (start_req)  st_d = ST_ARM;
            ST_ARM:  if (field_sync) st_d = ST_CAPT;
            ST_CAPT: if (last_fire)  st_d = ST_LAST;
            ST_LAST:                 st_d = ST_DONE;
            ST_DONE: if (!start_req) st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // State register and mode latch at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= 2'b00;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start_req) mode_q <= mode_in;
        end
    end

    // Status decode for the datapath and the bus switch.
    always_comb begin
        run     = (st_q == ST_CAPT);
        restart = field_sync && (st_q == ST_ARM || st_q == ST_CAPT);
        bus_own = (st_q == ST_ARM) || (st_q == ST_CAPT) || (st_q == ST_LAST);
        done    = (st_q == ST_DONE);
    end

    // R9: the geometry latched at acceptance never moves while the bus is owned.
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |=> $stable(mode_q));

    // R8: done is held while the request stays high.
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start_req) |=> done);

endmodule

// File: rtl/fcap_count.sv
// Pixel and line counters with the registered write port.
// Counters clear on restart. A line sync clears the pixel number and
// moves the line. Strobes past the line end or the frame end are dropped.
// Assumes w_last and h_last stay stable while run is high.
module fcap_count #(
    parameter int BASE_LOG = 8,
    parameter int DATA_W   = 8,
    localparam int SPAN_W  = BASE_LOG + 1,
    localparam int ADDR_W  = 2 * SPAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              field_sync,
    input  logic              line_sync,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              wide,
    input  logic [SPAN_W-1:0] w_last,
    input  logic [SPAN_W-1:0] h_last,
    output logic              last_fire,
    output logic              cap_we,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    logic [SPAN_W-1:0] pix_q, line_q;
    logic              line_full_q, frame_over_q;
    logic              wr_fire;
    logic [ADDR_W-1:0] addr_now;

    // Decide whether this cycle's strobe is written.
    always_comb begin
        wr_fire   = run && pix_valid && !line_sync && !field_sync
                    && !line_full_q && !frame_over_q;
        last_fire = wr_fire && (pix_q == w_last) && (line_q == h_last);
    end

    // Form the RAM address from the line and pixel numbers.
    always_comb begin
        if (wide) addr_now = {line_q, {SPAN_W{1'b0}}} | ADDR_W'(pix_q);
        else      addr_now = (ADDR_W'(line_q) << BASE_LOG) | ADDR_W'(pix_q);
    end

    // Pixel and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pix_q        <= '0;
            line_q       <= '0;
            line_full_q  <= 1'b0;
            frame_over_q <= 1'b0;
        end else if (run) begin
            if (line_sync) begin
                pix_q       <= '0;
                line_full_q <= 1'b0;
                if (line_q == h_last) frame_over_q <= 1'b1;
                else                  line_q <= line_q + 1'b1;
            end else if (wr_fire) begin
                if (pix_q == w_last) line_full_q <= 1'b1;
                else                 pix_q <= pix_q + 1'b1;
            end
        end
    end

    // Registered write port towards the bus switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_we   <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            cap_we <= wr_fire;
            if (wr_fire) begin
                cap_addr <= addr_now;
                cap_data <= adc_data;
            end
        end
    end

    // R4: a write inside a line advances the pixel number by one.
    a_r4_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && pix_q != w_last) |=> (pix_q == $past(pix_q) + 1'b1));

    // R5: a line sync during capture leaves the pixel number at zero.
    a_r5_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_sync) |=> (pix_q == '0));

    // R5: no write follows a line-sync cycle.
    a_r5_no_write_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync |=> !cap_we);

endmodule

// File: rtl/fcap_busmux.sv
// RAM bus switch: the capture port drives the RAM while owned,
// otherwise the processor lines pass straight through.
module fcap_busmux #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              own,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              cap_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we
);
    // Select the bus master.
    always_comb begin
        ram_addr  = own ? cap_addr : cpu_addr;
        ram_wdata = own ? cap_data : cpu_wdata;
        ram_we    = own ? cap_we   : cpu_we;
    end

endmodule

// File: rtl/frame_capture_agen.sv
// Frame capture address generator top: joins the sequencer, the geometry
// decoder, the counters and the bus switch.
// Assumes all sync and strobe inputs are already synchronous to clk.
module frame_capture_agen #(
    parameter int BASE_LOG = 8,
    parameter int DATA_W   = 8,
    localparam int SPAN_W  = BASE_LOG + 1,
    localparam int ADDR_W  = 2 * SPAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [1:0]        mode_sel,
    output logic              done,
    input  logic              field_sync,
    input  logic              line_sync,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              bus_own
);
    logic [1:0]        mode_q;
    logic              run, restart, last_fire, wide;
    logic [SPAN_W-1:0] w_last, h_last;
    logic              cap_we;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    fcap_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .mode_in    (mode_sel),
        .field_sync (field_sync),
        .last_fire  (last_fire),
        .mode_q     (mode_q),
        .run        (run),
        .restart    (restart),
        .bus_own    (bus_own),
        .done       (done)
    );

    fcap_geom #(.BASE_LOG(BASE_LOG)) u_geom (
        .mode   (mode_q),
        .wide   (wide),
        .w_last (w_last),
        .h_last (h_last)
    );

    fcap_count #(.BASE_LOG(BASE_LOG), .DATA_W(DATA_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (restart),
        .field_sync (field_sync),
        .line_sync  (line_sync),
        .pix_valid  (pix_valid),
        .adc_data   (adc_data),
        .wide       (wide),
        .w_last     (w_last),
        .h_last     (h_last),
        .last_fire  (last_fire),
        .cap_we     (cap_we),
        .cap_addr   (cap_addr),
        .cap_data   (cap_data)
    );

    fcap_busmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .own       (bus_own),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .cap_we    (cap_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we)
    );

    // R2: a capture write is only ever presented while the bus is owned.
    a_r2_we_owned: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> bus_own);

    // R7: done rises only right after the final capture write.
    a_r7_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cap_we));

endmodule

// File: tb/frame_capture_agen_bench.sv
module frame_capture_agen_bench;
    localparam int BASE = 3;
    localparam int AW   = 2 * (BASE + 1);
    localparam int DW   = 8;

    // Vector fields: [9:8] mode, [7:6] mode driven during capture,
    // [5:3] expected log2 width, [2:0] expected log2 height.
    localparam logic [9:0] VEC [4] = '{
        {2'b00, 2'b01, 3'd3, 3'd3},
        {2'b01, 2'b10, 3'd4, 3'd4},
        {2'b10, 2'b11, 3'd3, 3'd2},
        {2'b11, 2'b00, 3'd4, 3'd3}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start_req, done, field_sync, line_sync, pix_valid;
    logic          cpu_we, ram_we, bus_own;
    logic [1:0]    mode_sel;
    logic [DW-1:0] adc_data, cpu_wdata, ram_wdata;
    logic [AW-1:0] cpu_addr, ram_addr;

    frame_capture_agen #(.BASE_LOG(BASE), .DATA_W(DW)) u_frame_capture_agen (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_sel(mode_sel),
        .done(done), .field_sync(field_sync), .line_sync(line_sync),
        .pix_valid(pix_valid), .adc_data(adc_data), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .bus_own(bus_own)
    );

    int checks = 0;
    int fails  = 0;
    int exp_idx = 0;
    int wr_cnt  = 0;
    int cur_wl  = 3;
    bit fs_seen = 1'b0;
    bit finished = 1'b0;

    function automatic logic [7:0] pat(int l, int p);
        return 8'((l * 5 + p * 3 + 1) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Write monitor: R3 (nothing before field start), R4 (address order and data).
    always @(posedge clk) begin
        #2;
        if (rst_n && bus_own && ram_we) begin
            if (!fs_seen) begin
                chk(1'b0, "R3 write before field sync", int'(ram_addr), -1);
            end else begin
                chk(int'(ram_addr) == exp_idx, "R4 address", int'(ram_addr), exp_idx);
                chk(ram_wdata == pat(exp_idx >> cur_wl, exp_idx & ((1 << cur_wl) - 1)),
                    "R4 data", int'(ram_wdata),
                    int'(pat(exp_idx >> cur_wl, exp_idx & ((1 << cur_wl) - 1))));
                exp_idx++;
                wr_cnt++;
            end
        end
    end

    // Field start, then nlines lines, each with two strobes past the line end.
    task automatic drive_frame(int wl, int nlines, int coincide_line);
        int w;
        w = 1 << wl;
        field_sync = 1'b1; exp_idx = 0; wr_cnt = 0; fs_seen = 1'b1;
        tick;
        field_sync = 1'b0;
        for (int l = 0; l < nlines; l++) begin
            if (l > 0) begin
                line_sync = 1'b1;
                if (l == coincide_line) begin pix_valid = 1'b1; adc_data = 8'hEE; end
                tick;
                line_sync = 1'b0; pix_valid = 1'b0;
            end
            for (int p = 0; p < w + 2; p++) begin
                pix_valid = 1'b1; adc_data = pat(l, p);
                tick;
                if (p % 3 == 2) begin pix_valid = 1'b0; tick; end
            end
            pix_valid = 1'b0;
            tick;
        end
    endtask

    task automatic wait_done;
        for (int k = 0; k < 60; k++) if (!done) tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R7 watchdog actual=0 expected=1");
            summary;
        end
    end

    initial begin
        rst_n = 1'b0; start_req = 1'b0; mode_sel = 2'b00; field_sync = 1'b0;
        line_sync = 1'b0; pix_valid = 1'b0; adc_data = '0;
        cpu_addr = 8'h3C; cpu_wdata = 8'h11; cpu_we = 1'b1;
        repeat (3) tick;
        // R1: reset state and pass-through
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(bus_own == 1'b0, "R1 bus_own", int'(bus_own), 0);
        chk(ram_we == 1'b1, "R1 ram_we", int'(ram_we), 1);
        chk(ram_addr == 8'h3C, "R1 ram_addr", int'(ram_addr), 'h3C);
        rst_n = 1'b1; cpu_we = 1'b0;
        tick;
        // R2: no request, no ownership
        repeat (4) tick;
        chk(bus_own == 1'b0, "R2 idle without request", int'(bus_own), 0);

        // Vector walk over all geometries (R6), with mode and request changes (R9).
        for (int i = 0; i < 4; i++) begin
            int wl, hl;
            wl = int'(VEC[i][5:3]); hl = int'(VEC[i][2:0]);
            cur_wl = wl; fs_seen = 1'b0;
            mode_sel = VEC[i][9:8]; start_req = 1'b1;
            tick;
            chk(bus_own == 1'b1, "R2 ownership after accept", int'(bus_own), 1);
            chk(done == 1'b0, "R2 done low in capture", int'(done), 0);
            mode_sel = VEC[i][7:6];
            cpu_we = 1'b1; cpu_addr = 8'h77;
            for (int k = 0; k < 3; k++) begin
                pix_valid = 1'b1; adc_data = 8'h99;
                tick;
                chk(ram_we == 1'b0, "R2 processor write blocked", int'(ram_we), 0);
            end
            pix_valid = 1'b0; cpu_we = 1'b0;
            start_req = 1'b0; tick; start_req = 1'b1;
            tick;
            chk(bus_own == 1'b1, "R9 request drop ignored", int'(bus_own), 1);
            drive_frame(wl, 1 << hl, (i == 1) ? 1 : -1);
            wait_done;
            chk(done == 1'b1, "R7 done after frame", int'(done), 1);
            chk(bus_own == 1'b0, "R7 bus released", int'(bus_own), 0);
            chk(wr_cnt == (1 << (wl + hl)), "R6 bytes per frame", wr_cnt, 1 << (wl + hl));
            repeat (3) tick;
            chk(done == 1'b1, "R8 done held", int'(done), 1);
            start_req = 1'b0;
            tick;
            chk(done == 1'b0, "R8 done cleared", int'(done), 0);
            chk(bus_own == 1'b0, "R8 idle", int'(bus_own), 0);
        end

        // R11: field sync in the middle of a capture restarts the frame.
        cur_wl = 3; fs_seen = 1'b0;
        mode_sel = 2'b00; start_req = 1'b1;
        tick;
        drive_frame(3, 3, -1);
        chk(done == 1'b0, "R11 partial frame not done", int'(done), 0);
        drive_frame(3, 8, -1);
        wait_done;
        chk(done == 1'b1, "R11 done after restart", int'(done), 1);
        chk(wr_cnt == 64, "R11 full frame after restart", wr_cnt, 64);
        start_req = 1'b0;
        tick;

        // R10: released bus follows the processor.
        cpu_addr = 8'hA5; cpu_wdata = 8'h5A; cpu_we = 1'b1;
        tick;
        chk(ram_addr == 8'hA5, "R10 address", int'(ram_addr), 'hA5);
        chk(ram_wdata == 8'h5A, "R10 data", int'(ram_wdata), 'h5A);
        chk(ram_we == 1'b1, "R10 write enable", int'(ram_we), 1);
        cpu_we = 1'b0;
        tick;
        summary;
    end

endmodule